// File: doc/BRIEF.md
# Flash Erase-Status Responder

This block is a synthesizable model of the command side of a flash die, limited to the feature that tells a host whether an earlier erase of a sector really finished. It sits on a word-wide read/write bus. It keeps one erase-complete flag per sector, and a testbench or a surrounding model fills these flags through a separate load port.

A host asks about a sector by writing the evaluation command to any address inside that sector. The device then stays busy for a fixed number of clock cycles. At the end of that interval it copies the sector's flag into the status word. This command does not change what reads return.

To see the status word, the host first writes the status-read command. The next read then returns the status word, whatever address it uses. That same read switches the bus back to array data. Array reads return a fixed pattern computed from the address, so status data and array data are easy to tell apart.

Top module: `erase_status_responder`

## Requirements
- R1: After reset no status read is armed, the device is ready, and the latched erase result is 0. The first status word read after reset is 0x0080, and bus_rvalid is low.
- R2: A read issued at a clock edge sets bus_rvalid high for exactly the following cycle. When no status read is armed, bus_rdata in that cycle equals the zero-extended address XOR ARRAY_KEY (default 16'hA5C3).
- R3: A write whose full data word is 0x0070 arms a status read. The next read returns the status word at any address.
- R4: A read that returns the status word disarms status mode, so the read after it returns array data again.
- R5: A write whose full data word is 0x00D0 starts an evaluation, and the device goes busy. While busy, the status word reads 0x0000: bit 7 is 0 (busy) and bits 6..0 are 0.
- R6: A read issued at the clock edge EVAL_CYCLES cycles after the evaluation write edge still sees busy. A read issued one edge later sees ready.
- R7: When the evaluation ends, the status word is 0x0081 if the selected sector's flag is 1 and 0x0080 if it is 0. The sector is taken from bus_addr[SECT_LSB +: SECT_W] at the evaluation write.
- R8: The evaluation command does not arm a status read. A read after it, with no 0x0070 write in between, returns array data.
- R9: Sector flags reset to 0. A load-port cycle with ld_en high sets flag ld_sector to ld_flag.
- R10: A write of any other data word (including 0x00FF, 0x1070 and 0x00D1) changes neither the armed state nor the latched status, and does not start an evaluation.
- R11: A write presented in the same cycle as a read is ignored. Only the read takes effect.
- R12: An evaluation command received while busy restarts the interval for the newly addressed sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | DATA_W | Write data, decoded as a command |
| bus_rdata | output | DATA_W | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High the cycle after a read |
| ld_en | input | 1 | Flag load strobe |
| ld_sector | input | SECT_W | Sector whose flag is loaded |
| ld_flag | input | 1 | Erase-complete value to store |

## Verification
The bench builds the block with EVAL_CYCLES = 40 instead of the 8750-cycle default. This makes it practical to probe both edges of the busy window (R6) and to restart an evaluation in flight (R12). It uses 8 sectors with the sector field at address bits 10..8 and a 12-bit address. With these values, every sector can be named by an ordinary address, and addresses far outside the sector field can be used for status reads to show that the address does not matter.

// File: rtl/esr_pkg.sv
// Package: shared command codes, status bit positions and the decoded command type
// for the erase-status responder. Assumes a data bus of at least 8 bits.
package esr_pkg;

    localparam logic [7:0] CODE_EVAL = 8'hD0;  // evaluate erase status of a sector
    localparam logic [7:0] CODE_STAT = 8'h70;  // arm one status-word read
    localparam int         READY_BIT = 7;      // 1 = ready, 0 = busy
    localparam int         ERASE_BIT = 0;      // 1 = sector fully erased

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_EVAL,
        CMD_STAT
    } esr_cmd_e;

endpackage

// File: rtl/esr_cmd_decode.sv
// Command decoder: classifies one bus write as evaluate, status-arm or nothing.
// Assumes commands compare against the whole data word; a write in the same
// cycle as a read is dropped so the read alone takes effect.
module esr_cmd_decode
    import esr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output esr_cmd_e          cmd
);

    localparam logic [DATA_W-1:0] EVAL_WORD = DATA_W'(CODE_EVAL);
    localparam logic [DATA_W-1:0] STAT_WORD = DATA_W'(CODE_STAT);

    // Purpose: map a qualified write onto a command code.
    always_comb begin
        cmd = CMD_NONE;
        if (wr && !rd) begin
            if (wdata == EVAL_WORD) begin
                cmd = CMD_EVAL;
            end else if (wdata == STAT_WORD) begin
                cmd = CMD_STAT;
            end
        end
    end

endmodule

// File: rtl/esr_flag_store.sv
// Flag store: one erase-complete bit per sector, written through the load port
// and read combinationally at the sector the timer selects. Assumes an index at
// or above NUM_SECTORS reads as 0.
module esr_flag_store #(
    parameter int NUM_SECTORS = 16,
    parameter int SECT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [SECT_W-1:0] ld_sector,
    input  logic              ld_flag,
    input  logic [SECT_W-1:0] sel_sector,
    output logic              sel_flag
);

    logic [NUM_SECTORS-1:0] flags;

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_flag
        // Purpose: hold the flag of sector s, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[s] <= 1'b0;
            end else if (ld_en && (int'(ld_sector) == s)) begin
                flags[s] <= ld_flag;
            end
        end
    end

    // Purpose: return the flag of the selected sector, 0 when out of range.
    always_comb begin
        sel_flag = 1'b0;
        for (int s = 0; s < NUM_SECTORS; s++) begin
            if (int'(sel_sector) == s) begin
                sel_flag = flags[s];
            end
        end
    end

endmodule

// File: rtl/esr_eval_timer.sv
// Evaluation timer: on an evaluate command it captures the sector, goes busy
// for EVAL_CYCLES clocks, then latches that sector's flag as the erase result.
// A new command while busy restarts the interval.
module esr_eval_timer #(
    parameter int EVAL_CYCLES = 8750,
    parameter int SECT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SECT_W-1:0] start_sector,
    input  logic              sel_flag,
    output logic [SECT_W-1:0] sel_sector,
    output logic              busy,
    output logic              erase_ok
);

    localparam int CNT_W = $clog2(EVAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(EVAL_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Purpose: run the busy countdown and latch the result when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            remain     <= '0;
            sel_sector <= '0;
            erase_ok   <= 1'b0;
        end else if (start) begin
            busy       <= 1'b1;
            remain     <= LOAD_VAL;
            sel_sector <= start_sector;
            erase_ok   <= 1'b0;
        end else if (busy) begin
            if (remain == '0) begin
                busy     <= 1'b0;
                erase_ok <= sel_flag;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/esr_read_port.sv
// Read port: keeps the one-shot status arm and registers read data. An armed
// read returns the status word and disarms; otherwise the read returns the
// address pattern. Assumes DATA_W >= 8.
module esr_read_port
    import esr_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter int              ADDR_W    = 16,
    parameter logic [DATA_W-1:0] ARRAY_KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  esr_cmd_e          cmd,
    input  logic              busy,
    input  logic              erase_ok,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              armed
);

    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] array_word;

    // Purpose: assemble the status word; the erase bit is masked while busy.
    always_comb begin
        status_word            = '0;
        status_word[READY_BIT] = ~busy;
        status_word[ERASE_BIT] = ~busy & erase_ok;
    end

    // Purpose: address-derived array pattern.
    always_comb begin
        array_word = DATA_W'(addr) ^ ARRAY_KEY;
    end

    // Purpose: arm on the status command, disarm on any read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (rd) begin
            armed <= 1'b0;
        end else if (cmd == CMD_STAT) begin
            armed <= 1'b1;
        end
    end

    // Purpose: register read data and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) begin
                rdata <= armed ? status_word : array_word;
            end
        end
    end

endmodule

// File: rtl/erase_status_responder.sv
// Top: flash erase-status responder. Decodes bus writes, runs the evaluation
// timer against the per-sector flag store, and overlays the status word on
// one read after a status command. Assumes single-cycle read/write strobes.
module erase_status_responder
    import esr_pkg::*;
#(
    parameter int              DATA_W      = 16,
    parameter int              ADDR_W      = 16,
    parameter int              NUM_SECTORS = 16,
    parameter int              SECT_LSB    = 12,
    parameter int              CLK_MHZ     = 125,
    parameter int              EVAL_US     = 70,
    parameter int              EVAL_CYCLES = CLK_MHZ * EVAL_US,
    parameter logic [DATA_W-1:0] ARRAY_KEY = 16'hA5C3,
    localparam int             SECT_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              ld_en,
    input  logic [SECT_W-1:0] ld_sector,
    input  logic              ld_flag
);

    esr_cmd_e          cmd;
    logic [SECT_W-1:0] addr_sector;
    logic [SECT_W-1:0] sel_sector;
    logic              sel_flag;
    logic              eval_busy;
    logic              erase_ok;
    logic              stat_armed;

    // Purpose: pick the sector field out of the write address.
    always_comb begin
        addr_sector = bus_addr[SECT_LSB +: SECT_W];
    end

    esr_cmd_decode #(
        .DATA_W (DATA_W)
    ) u_decode (
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    esr_flag_store #(
        .NUM_SECTORS (NUM_SECTORS),
        .SECT_W      (SECT_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_sector  (ld_sector),
        .ld_flag    (ld_flag),
        .sel_sector (sel_sector),
        .sel_flag   (sel_flag)
    );

    esr_eval_timer #(
        .EVAL_CYCLES (EVAL_CYCLES),
        .SECT_W      (SECT_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (cmd == CMD_EVAL),
        .start_sector (addr_sector),
        .sel_flag     (sel_flag),
        .sel_sector   (sel_sector),
        .busy         (eval_busy),
        .erase_ok     (erase_ok)
    );

    esr_read_port #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .ARRAY_KEY (ARRAY_KEY)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .cmd      (cmd),
        .busy     (eval_busy),
        .erase_ok (erase_ok),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid),
        .armed    (stat_armed)
    );

endmodule

// File: rtl/esr_checker.sv
// Checker: temporal properties of the erase-status responder, bound to the top.
// Watches the bus ports plus the busy and armed state; the busy window is
// measured with a local counter rather than a long $past.
module esr_checker #(
    parameter int DATA_W      = 16,
    parameter int EVAL_CYCLES = 8750
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              busy,
    input logic              armed
);

    logic        wr_only;
    logic        is_eval;
    logic        is_stat;
    logic        is_other;
    logic [31:0] busy_len;

    assign wr_only  = bus_wr && !bus_rd;
    assign is_eval  = wr_only && (bus_wdata == DATA_W'(8'hD0));
    assign is_stat  = wr_only && (bus_wdata == DATA_W'(8'h70));
    assign is_other = wr_only && !is_eval && !is_stat;

    // Purpose: count the cycles since the last evaluation write while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (is_eval) begin
            busy_len <= 32'd1;
        end else if (busy) begin
            busy_len <= busy_len + 32'd1;
        end
    end

    assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    assert_rvalid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    assert_arm_on_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_stat |=> armed);
    assert_disarm_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !armed);
    assert_eval_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_eval |=> busy);
    assert_busy_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && armed && busy) |=> (bus_rdata == '0));
    assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 32'(EVAL_CYCLES + 1)));
    assert_ready_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && armed && !busy) |=> (bus_rdata[DATA_W-1:1] == (DATA_W-1)'(7'h40)));
    assert_eval_no_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_eval && !armed) |=> !armed);
    assert_other_keeps_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_other |=> $stable(armed));
    assert_other_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_other && !busy) |=> !busy);
    assert_read_write_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr && !busy) |=> !busy);

endmodule

bind erase_status_responder esr_checker #(
    .DATA_W      (DATA_W),
    .EVAL_CYCLES (EVAL_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .busy       (eval_busy),
    .armed      (stat_armed)
);

// File: tb/erase_status_responder_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard. Read tasks queue the expected word; a negedge monitor
// pops and compares each valid read result.
module erase_status_responder_bench;

    localparam int          DW    = 16;
    localparam int          AW    = 12;
    localparam int          NSEC  = 8;
    localparam int          N     = 40;
    localparam logic [15:0] KEY   = 16'hA5C3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic          ld_en = 1'b0;
    logic [2:0]    ld_sector = '0;
    logic          ld_flag = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    erase_status_responder #(
        .DATA_W      (DW),
        .ADDR_W      (AW),
        .NUM_SECTORS (NSEC),
        .SECT_LSB    (8),
        .EVAL_CYCLES (N),
        .ARRAY_KEY   (KEY)
    ) u_erase_status_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .ld_en      (ld_en),
        .ld_sector  (ld_sector),
        .ld_flag    (ld_flag)
    );

    function automatic logic [15:0] arr(input logic [AW-1:0] a);
        return {4'b0, a} ^ KEY;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr_cmd(input logic [AW-1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic load(input int s, input logic f);
        ld_en = 1'b1; ld_sector = 3'(s); ld_flag = f;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            if (sb.size() != 0) begin
                n_tests++; n_fail++;
                $display("FAIL scoreboard: %0d reads never answered, expected 0", sb.size());
            end
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare each valid read against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid && !done) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected read data %h, expected none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected end");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (bus_rvalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rvalid %b expected 0", bus_rvalid);
        end
        #1;
        // R1: reset status word
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h000, 16'h0080, "R1 reset status");
        // R2, R4: array reads, including right after a status read
        rd_exp(12'h000, arr(12'h000), "R4 array after status");
        rd_exp(12'h123, arr(12'h123), "R2 array");
        rd_exp(12'hFFF, arr(12'hFFF), "R2 array");
        // R3: status at an arbitrary address
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h7A5, 16'h0080, "R3 status any addr");
        // R9: flags reset to 0, sector 0 not erased
        wr_cmd(12'h010, 16'h00D0);
        idle(N + 2);
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h0AB, 16'h0080, "R9 reset flag 0");
        load(3, 1'b1);
        load(6, 1'b1);
        // R7: erased sector reads 0x81, R8: eval does not arm
        wr_cmd(12'h345, 16'h00D0);
        rd_exp(12'h345, arr(12'h345), "R8 eval no arm");
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h000, 16'h0000, "R5 busy word");
        idle(N + 2);
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'hF00, 16'h0081, "R7 erased sector");
        // R7: incompletely erased sector
        wr_cmd(12'h5FF, 16'h00D0);
        idle(N + 2);
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h001, 16'h0080, "R7 not erased");
        // R6: last busy edge
        wr_cmd(12'h600, 16'h00D0);
        wr_cmd(12'h000, 16'h0070);
        idle(N - 2);
        rd_exp(12'h002, 16'h0000, "R6 last busy edge");
        idle(4);
        // R6: first ready edge
        wr_cmd(12'h600, 16'h00D0);
        wr_cmd(12'h000, 16'h0070);
        idle(N - 1);
        rd_exp(12'h003, 16'h0081, "R6 first ready edge");
        // R10: other words do not arm, disarm or start an evaluation
        wr_cmd(12'h000, 16'h00FF);
        wr_cmd(12'h000, 16'h1070);
        rd_exp(12'h044, arr(12'h044), "R10 no arm");
        wr_cmd(12'h000, 16'h0070);
        wr_cmd(12'h000, 16'h0055);
        rd_exp(12'h045, 16'h0081, "R10 stays armed");
        wr_cmd(12'h100, 16'h00D1);
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h046, 16'h0081, "R10 no eval");
        // R11: write alongside a read is dropped
        bus_wr = 1'b1; bus_wdata = 16'h0070;
        rd_exp(12'h050, arr(12'h050), "R11 read wins");
        bus_wr = 1'b0;
        rd_exp(12'h051, arr(12'h051), "R11 write dropped");
        bus_wr = 1'b1; bus_wdata = 16'h00D0;
        rd_exp(12'h052, arr(12'h052), "R11 read wins");
        bus_wr = 1'b0;
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h053, 16'h0081, "R11 no eval");
        // R12: restart in flight to a non-erased sector
        wr_cmd(12'h300, 16'h00D0);
        idle(10);
        wr_cmd(12'h500, 16'h00D0);
        wr_cmd(12'h000, 16'h0070);
        idle(N - 8);
        rd_exp(12'h060, 16'h0000, "R12 still busy after restart");
        idle(20);
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h061, 16'h0080, "R12 new sector result");
        // R9: reload a flag to 0
        load(3, 1'b0);
        wr_cmd(12'h300, 16'h00D0);
        idle(N + 2);
        wr_cmd(12'h000, 16'h0070);
        rd_exp(12'h062, 16'h0080, "R9 reloaded flag");
        idle(3);
        finish_run();
    end

endmodule